// File: doc/BRIEF.md
# QPI command frame decoder

This block is the slave-side front end of a serial flash driven over four data lines. Chip select and the four input lines are sampled on each rising edge of `clk`, and every edge with `cs_n` low counts as one bus clock. Each bus clock moves one nibble, so a byte takes two clocks with the high nibble first. The first byte of a frame is the opcode. A fixed opcode table then picks what follows it: a 24-bit address, a mode byte, dummy clocks, a data-in phase or a data-out phase.

The decoder reports the opcode it captured and the assembled address, with a one-clock `addr_valid` pulse. It delivers each data-in byte with a pulse and a running count, and raises `dout_start` in the clock where the device should begin driving read data. When `cs_n` is first sampled high after a frame, the decoder pulses `frame_done`, but only if every phase the command needs has arrived and the frame stopped on a byte boundary. A reset command raises `rst_fire` only when the complete frame just before it was a reset-enable. Driving the output lines, accessing the array and running erase or program operations belong to other blocks.

Top module: `qpi_frame_decoder`

## Requirements
- R1: After reset, all strobes (`addr_valid`, `rx_valid`, `dout_start`, `frame_done`, `rst_fire`) are 0, and `opcode_o`, `addr_o` and `rx_count` are 0.
- R2: The opcode is assembled from the first two bus clocks of a frame, high nibble first. `opcode_o` shows it from the second clock onward.
- R3: Opcodes 0Bh, EBh, 20h, 52h, D8h and 02h take six address clocks, most significant nibble first. `addr_valid` pulses for one clock after the sixth, and `addr_o` then holds the address.
- R4: For 20h, bits below SECTOR_LSB (default 12) of `addr_o` are forced to 0. For 52h and D8h the address is passed unchanged.
- R5: `dout_start` pulses for one clock. For 05h it pulses right after the opcode. For 0Bh it pulses after the address plus FAST_DUMMY clocks. For EBh it pulses after the address, two mode-byte clocks and QIO_DUMMY clocks.
- R6: For 02h, each pair of clocks after the address yields one byte, high nibble first. Each byte raises `rx_valid` with `rx_data`, and `rx_count` counts it (from 1). Bytes beyond MAX_PROG raise no pulse and leave `rx_count` at MAX_PROG.
- R7: For 01h exactly one data byte is accepted. Later clocks in the same frame produce no `rx_valid`, and `rx_count` stays 1.
- R8: `frame_done` pulses for one clock at the first clock with `cs_n` high after a complete frame. 06h, 04h, 60h, C7h, B0h, 30h, B9h, 66h and 99h are complete after the opcode.
- R9: A frame is aborted, with no `frame_done`, if `cs_n` rises mid-byte or before a required phase ends. Required phases are the address, the mode byte and the dummy clocks, plus at least one whole data byte for 02h and 01h.
- R10: A frame with an opcode outside the table produces no strobe of any kind until `cs_n` rises.
- R11: A complete 99h frame raises `rst_fire` together with `frame_done` only when the frame just before it was a complete 66h. Any other frame in between, aborted or unknown included, disarms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every rising edge with `cs_n` low is one bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; a high sample ends the frame |
| sio_in | input | 4 | Sampled data nibble |
| opcode_o | output | 8 | Most recently captured opcode |
| addr_o | output | 24 | Most recently assembled address, masked for 20h |
| addr_valid | output | 1 | One-clock pulse when the address is complete |
| rx_data | output | 8 | Last accepted data-in byte |
| rx_valid | output | 1 | One-clock pulse per accepted data-in byte |
| rx_count | output | RC_W (9) | Data bytes accepted in the current frame |
| dout_start | output | 1 | One-clock pulse when the data-out phase begins |
| frame_done | output | 1 | One-clock pulse at the end of a complete frame |
| rst_fire | output | 1 | One-clock pulse for an armed reset command |

## Verification
The bench predicts the exact clock of every strobe from the dummy counts. A decoder that miscounts dummy or mode clocks therefore shows up as a `dout_start` arriving early or late, not only as a wrong value. Page program is driven past 256 bytes and write status with a second byte. A missing cap would give extra `rx_valid` pulses and a count that wraps or keeps climbing. The bench ends frames mid-address, mid-byte, mid-opcode and during dummy clocks, expecting no `frame_done`, and runs reset-enable sequences broken by another command and by an aborted frame. A decoder that confused completion with activity, or kept the arming across frames, would raise a spurious command or reset strobe.

// File: rtl/qpi_frame_decoder.sv
module qpi_frame_decoder #(
  parameter int FAST_DUMMY = 8,
  parameter int QIO_DUMMY  = 6,
  parameter int MAX_PROG   = 256,
  parameter int SECTOR_LSB = 12,
  localparam int RC_W = $clog2(MAX_PROG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic [3:0]      sio_in,
  output logic [7:0]      opcode_o,
  output logic [23:0]     addr_o,
  output logic            addr_valid,
  output logic [7:0]      rx_data,
  output logic            rx_valid,
  output logic [RC_W-1:0] rx_count,
  output logic            dout_start,
  output logic            frame_done,
  output logic            rst_fire
);

  localparam int DMAX  = (FAST_DUMMY > QIO_DUMMY) ? FAST_DUMMY : QIO_DUMMY;
  localparam int CLIM  = (DMAX > 6) ? DMAX : 6;
  localparam int CNT_W = $clog2(CLIM + 1);
  localparam logic [23:0] SECT_MASK = ~((24'h1 << SECTOR_LSB) - 24'h1);

  typedef enum logic [3:0] {
    P_IDLE, P_OPC, P_ADDR, P_MODE, P_DUMMY, P_DIN, P_DOUT, P_DONE, P_SKIP
  } phase_t;

  function automatic logic op_known(input logic [7:0] op);
    case (op)
      8'h0B, 8'hEB, 8'h20, 8'h52, 8'hD8, 8'h02, 8'h05, 8'h01,
      8'h06, 8'h04, 8'h60, 8'hC7, 8'hB0, 8'h30, 8'hB9, 8'h66, 8'h99: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_has_addr(input logic [7:0] op);
    case (op)
      8'h0B, 8'hEB, 8'h20, 8'h52, 8'hD8, 8'h02: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic phase_t tail_phase(input logic [7:0] op);
    case (op)
      8'h05:        return P_DOUT;
      8'h01, 8'h02: return P_DIN;
      default:      return P_DONE;
    endcase
  endfunction

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       hi_q;
  logic [19:0]      addr_sh;
  logic             armed;

  wire [7:0]       byte_in  = {hi_q, sio_in};
  wire [23:0]      addr_in  = {addr_sh, sio_in};
  wire [RC_W-1:0]  rx_lim   = (opcode_o == 8'h01) ? RC_W'(1) : RC_W'(MAX_PROG);
  wire [CNT_W-1:0] dum_last = (opcode_o == 8'hEB) ? CNT_W'(QIO_DUMMY - 1)
                                                  : CNT_W'(FAST_DUMMY - 1);
  wire frame_ok = (phase == P_DONE) || (phase == P_DOUT) ||
                  (phase == P_DIN && !cnt[0] && rx_count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= P_IDLE;
      cnt        <= '0;
      hi_q       <= '0;
      addr_sh    <= '0;
      armed      <= 1'b0;
      opcode_o   <= '0;
      addr_o     <= '0;
      addr_valid <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_count   <= '0;
      dout_start <= 1'b0;
      frame_done <= 1'b0;
      rst_fire   <= 1'b0;
    end else begin
      addr_valid <= 1'b0;
      rx_valid   <= 1'b0;
      dout_start <= 1'b0;
      frame_done <= 1'b0;
      rst_fire   <= 1'b0;
      if (cs_n) begin
        if (phase != P_IDLE) begin
          frame_done <= frame_ok;
          rst_fire   <= frame_ok && opcode_o == 8'h99 && armed;
          armed      <= frame_ok && opcode_o == 8'h66;
          phase      <= P_IDLE;
        end
      end else begin
        cnt <= cnt + 1'b1;
        case (phase)
          P_IDLE: begin
            hi_q     <= sio_in;
            rx_count <= '0;
            phase    <= P_OPC;
          end
          P_OPC: begin
            opcode_o <= byte_in;
            cnt      <= '0;
            if (!op_known(byte_in)) phase <= P_SKIP;
            else if (op_has_addr(byte_in)) phase <= P_ADDR;
            else begin
              phase      <= tail_phase(byte_in);
              dout_start <= (byte_in == 8'h05);
            end
          end
          P_ADDR: begin
            addr_sh <= addr_in[19:0];
            if (cnt == CNT_W'(5)) begin
              cnt        <= '0;
              addr_valid <= 1'b1;
              addr_o     <= (opcode_o == 8'h20) ? (addr_in & SECT_MASK) : addr_in;
              if (opcode_o == 8'hEB) phase <= P_MODE;
              else if (opcode_o == 8'h0B) phase <= P_DUMMY;
              else phase <= tail_phase(opcode_o);
            end
          end
          P_MODE: begin
            if (cnt[0]) begin
              cnt   <= '0;
              phase <= P_DUMMY;
            end
          end
          P_DUMMY: begin
            if (cnt == dum_last) begin
              phase      <= P_DOUT;
              dout_start <= 1'b1;
            end
          end
          P_DIN: begin
            if (!cnt[0]) hi_q <= sio_in;
            else if (rx_count < rx_lim) begin
              rx_data  <= byte_in;
              rx_valid <= 1'b1;
              rx_count <= rx_count + 1'b1;
              if (opcode_o == 8'h01) phase <= P_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/qpi_frame_decoder_chk.sv
module qpi_frame_decoder_chk #(
  parameter int MAX_PROG   = 256,
  parameter int SECTOR_LSB = 12,
  parameter int RCW        = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic [7:0]      opcode_o,
  input logic [23:0]     addr_o,
  input logic            addr_valid,
  input logic            rx_valid,
  input logic [RCW-1:0]  rx_count,
  input logic            dout_start,
  input logic            frame_done,
  input logic            rst_fire
);

  localparam logic [23:0] LOW_MASK = (24'h1 << SECTOR_LSB) - 24'h1;

  // R3
  a_r3_addr_only_for_addr_ops: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (opcode_o == 8'h0B || opcode_o == 8'hEB || opcode_o == 8'h20 ||
                    opcode_o == 8'h52 || opcode_o == 8'hD8 || opcode_o == 8'h02));

  // R4
  a_r4_sector_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && opcode_o == 8'h20) |-> ((addr_o & LOW_MASK) == 24'h0));

  // R5
  a_r5_dout_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    dout_start |-> !$past(cs_n));

  // R6
  a_r6_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= RCW'(MAX_PROG));

  // R6
  a_r6_rx_only_for_write_ops: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (opcode_o == 8'h02 || opcode_o == 8'h01));

  // R7
  a_r7_single_status_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && opcode_o == 8'h01) |-> rx_count == RCW'(1));

  // R8
  a_r8_done_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(cs_n));

  // R8
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_valid, rx_valid, dout_start, frame_done}));

  // R11
  a_r11_reset_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rst_fire |-> (frame_done && opcode_o == 8'h99));

endmodule

bind qpi_frame_decoder qpi_frame_decoder_chk #(
  .MAX_PROG(MAX_PROG), .SECTOR_LSB(SECTOR_LSB), .RCW(RC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .opcode_o(opcode_o), .addr_o(addr_o),
  .addr_valid(addr_valid), .rx_valid(rx_valid), .rx_count(rx_count),
  .dout_start(dout_start), .frame_done(frame_done), .rst_fire(rst_fire)
);

// File: tb/qpi_frame_decoder_tb.sv
`timescale 1ns/1ps
module qpi_frame_decoder_tb;

  localparam int K_ADDR = 1, K_RX = 2, K_DOUT = 3, K_DONE = 4, K_RST = 5;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1;
  logic [3:0] sio = 4'h0;
  logic [7:0] opcode_o, rx_data;
  logic [23:0] addr_o;
  logic [8:0] rx_count;
  logic addr_valid, rx_valid, dout_start, frame_done, rst_fire;

  always #2 clk = ~clk;

  qpi_frame_decoder #(.FAST_DUMMY(4), .QIO_DUMMY(4), .MAX_PROG(256), .SECTOR_LSB(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sio_in(sio),
    .opcode_o(opcode_o), .addr_o(addr_o), .addr_valid(addr_valid),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_count(rx_count),
    .dout_start(dout_start), .frame_done(frame_done), .rst_fire(rst_fire));

  typedef struct { int kind; int val; int when; string tag; } ev_t;
  ev_t q[$];
  int cyc = 0, nvec = 0, nbad = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(int k, int v, string tag);
    ev_t e;
    e.kind = k; e.val = v; e.when = cyc + 1; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic sb_check(int k, int v);
    nvec++;
    if (q.size() == 0) begin
      nbad++;
      $display("FAIL R10 unexpected strobe kind %0d: actual %h expected none", k, v);
    end else if (q[0].kind != k || q[0].val != v || q[0].when != cyc) begin
      nbad++;
      $display("FAIL %s kind %0d cycle %0d: actual %h expected kind %0d value %h cycle %0d",
               q[0].tag, k, cyc, v, q[0].kind, q[0].val, q[0].when);
      if (q[0].when == cyc) void'(q.pop_front());
    end else void'(q.pop_front());
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      while (q.size() > 0 && q[0].when < cyc) begin
        nvec++; nbad++;
        $display("FAIL %s missing kind %0d: actual none expected %h at cycle %0d",
                 q[0].tag, q[0].kind, q[0].val, q[0].when);
        void'(q.pop_front());
      end
      if (addr_valid) sb_check(K_ADDR, int'(addr_o));
      if (rx_valid)   sb_check(K_RX, int'({rx_count, rx_data}));
      if (dout_start) sb_check(K_DOUT, int'(opcode_o));
      if (frame_done) sb_check(K_DONE, int'(opcode_o));
      if (rst_fire)   sb_check(K_RST, 0);
    end
  end

  task automatic nib(logic [3:0] n);
    cs_n = 1'b0; sio = n;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic send_op(logic [7:0] op, bit dout_now, string tag);
    nib(op[7:4]);
    if (dout_now) expect_ev(K_DOUT, int'(op), tag);
    nib(op[3:0]);
  endtask

  task automatic send_addr(logic [23:0] a, logic [23:0] exp_a, string tag);
    for (int i = 0; i < 6; i++) begin
      if (i == 5) expect_ev(K_ADDR, int'(exp_a), tag);
      nib(a[23 - 4*i -: 4]);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    nib(b[7:4]); nib(b[3:0]);
  endtask

  task automatic end_frame(bit ok, logic [7:0] op, bit rst, string tag);
    if (ok) expect_ev(K_DONE, int'(op), tag);
    if (rst) expect_ev(K_RST, 0, tag);
    cs_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(frame_done === ok && rst_fire === rst, tag, int'({frame_done, rst_fire}), int'({ok, rst}));
  endtask

  task automatic simple_cmd(logic [7:0] op, bit rst, string tag);
    send_op(op, 1'b0, tag);
    end_frame(1'b1, op, rst, tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    #(4 * 150000);
    nbad++;
    $display("FAIL R8 watchdog: actual hung expected finished run");
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    chk(opcode_o == 0 && addr_o == 0 && rx_count == 0, "R1 reset values",
        int'({opcode_o, rx_count}), 0);
    chk({addr_valid, rx_valid, dout_start, frame_done, rst_fire} == 0, "R1 reset strobes",
        int'({addr_valid, rx_valid, dout_start, frame_done, rst_fire}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R8: no-phase command
    simple_cmd(8'h06, 1'b0, "R8 write enable");
    chk(opcode_o == 8'h06, "R2 opcode capture", int'(opcode_o), 8'h06);
    simple_cmd(8'hC7, 1'b0, "R8 chip erase");
    chk(opcode_o == 8'hC7, "R2 opcode capture", int'(opcode_o), 8'hC7);

    // R3 / R5: fast read with 4 dummy clocks
    send_op(8'h0B, 1'b0, "R3 fast read");
    send_addr(24'h123456, 24'h123456, "R3 fast read address");
    for (int i = 0; i < 4; i++) begin
      if (i == 3) expect_ev(K_DOUT, 8'h0B, "R5 fast read dummy");
      nib(4'hF);
    end
    nib(4'h0); nib(4'h0);
    end_frame(1'b1, 8'h0B, 1'b0, "R8 fast read end");

    // R5: quad I/O read with mode byte
    send_op(8'hEB, 1'b0, "R3 quad read");
    send_addr(24'hABCDEF, 24'hABCDEF, "R3 quad read address");
    send_byte(8'hA0);
    for (int i = 0; i < 4; i++) begin
      if (i == 3) expect_ev(K_DOUT, 8'hEB, "R5 quad read mode+dummy");
      nib(4'h5);
    end
    nib(4'h0); nib(4'h0); nib(4'h0);
    end_frame(1'b1, 8'hEB, 1'b0, "R8 quad read end");

    // R4: sector erase masking, block erases unmasked
    send_op(8'h20, 1'b0, "R4 sector erase");
    send_addr(24'h345678, 24'h345678 & 24'hFFF000, "R4 sector mask");
    end_frame(1'b1, 8'h20, 1'b0, "R8 sector erase end");
    send_op(8'h52, 1'b0, "R4 block32");
    send_addr(24'h345678, 24'h345678, "R4 block32 unmasked");
    end_frame(1'b1, 8'h52, 1'b0, "R8 block32 end");
    send_op(8'hD8, 1'b0, "R4 block64");
    send_addr(24'hFEDCBA, 24'hFEDCBA, "R4 block64 unmasked");
    end_frame(1'b1, 8'hD8, 1'b0, "R8 block64 end");

    // R5: read status goes straight to data out
    send_op(8'h05, 1'b1, "R5 read status");
    nib(4'h0); nib(4'h0);
    end_frame(1'b1, 8'h05, 1'b0, "R8 read status end");

    // R7: write status takes one byte
    send_op(8'h01, 1'b0, "R7 write status");
    nib(4'h5);
    expect_ev(K_RX, (1 << 8) | 8'h5A, "R7 status byte");
    nib(4'hA);
    send_byte(8'hC3);
    end_frame(1'b1, 8'h01, 1'b0, "R7 write status end");
    chk(rx_count == 1 && rx_data == 8'h5A, "R7 extra byte ignored",
        int'({rx_count, rx_data}), (1 << 8) | 8'h5A);

    // R6: page program past the cap
    send_op(8'h02, 1'b0, "R6 page program");
    send_addr(24'h000100, 24'h000100, "R3 page program address");
    for (int i = 1; i <= 258; i++) begin
      b = 8'(i) ^ 8'h3C;
      nib(b[7:4]);
      if (i <= 256) expect_ev(K_RX, (i << 8) | int'(b), "R6 program byte");
      nib(b[3:0]);
    end
    end_frame(1'b1, 8'h02, 1'b0, "R6 page program end");
    chk(rx_count == 256, "R6 count capped", int'(rx_count), 256);

    // R9: aborted frames
    send_op(8'h0B, 1'b0, "R9 abort in address");
    nib(4'h1); nib(4'h2); nib(4'h3);
    end_frame(1'b0, 8'h0B, 1'b0, "R9 abort in address");
    nib(4'h0);
    end_frame(1'b0, 8'h00, 1'b0, "R9 abort in opcode");
    send_op(8'h02, 1'b0, "R9 abort mid data byte");
    send_addr(24'h00AA00, 24'h00AA00, "R3 program address");
    nib(4'h7);
    expect_ev(K_RX, (1 << 8) | 8'h77, "R6 first byte");
    nib(4'h7);
    nib(4'h1);
    end_frame(1'b0, 8'h02, 1'b0, "R9 abort mid data byte");
    send_op(8'hEB, 1'b0, "R9 abort in dummy");
    send_addr(24'h000042, 24'h000042, "R3 quad read address");
    send_byte(8'h00);
    nib(4'h0); nib(4'h0);
    end_frame(1'b0, 8'hEB, 1'b0, "R9 abort in dummy");

    // R10: unknown opcode
    send_op(8'hA5, 1'b0, "R10 unknown");
    for (int i = 0; i < 8; i++) nib(4'(i));
    end_frame(1'b0, 8'hA5, 1'b0, "R10 unknown ignored");

    // R11: reset arming
    simple_cmd(8'h66, 1'b0, "R11 reset enable");
    simple_cmd(8'h99, 1'b1, "R11 armed reset");
    simple_cmd(8'h99, 1'b0, "R11 second reset not armed");
    simple_cmd(8'h66, 1'b0, "R11 reset enable");
    simple_cmd(8'h06, 1'b0, "R11 intervening frame");
    simple_cmd(8'h99, 1'b0, "R11 disarmed by command");
    simple_cmd(8'h66, 1'b0, "R11 reset enable");
    nib(4'h6);
    end_frame(1'b0, 8'h66, 1'b0, "R11 aborted frame");
    simple_cmd(8'h99, 1'b0, "R11 disarmed by abort");
    simple_cmd(8'h66, 1'b0, "R11 reset enable");
    send_op(8'h3C, 1'b0, "R11 unknown frame");
    end_frame(1'b0, 8'h3C, 1'b0, "R11 unknown frame");
    simple_cmd(8'h99, 1'b0, "R11 disarmed by unknown");

    repeat (4) @(negedge clk);
    finished = 1;
    while (q.size() > 0) begin
      nvec++; nbad++;
      $display("FAIL %s missing kind %0d: actual none expected %h", q[0].tag, q[0].kind, q[0].val);
      void'(q.pop_front());
    end
    summary();
    $finish;
  end

endmodule